// File: doc/BRIEF.md
# SMBus Register-Access Target

This block is an SMBus/I2C target that gives a bus master access to a small bank of 8-bit control registers. It takes SCL and SDA from an open-drain bus that has already been synchronised to the system clock. It debounces both lines, detects START and STOP, and moves through the bus transfer one byte at a time. It acknowledges or returns data by driving a single SDA pull-down enable.

A write has three bytes: an address with the write bit, a command byte whose two low bits pick the register, and a data byte. The data byte is staged and reaches the register only when the STOP arrives. If a repeated START comes before that STOP, the staged write is dropped. A read first sets the register index with a command byte. It then uses a repeated START and the address with the read bit, and the block shifts the selected register out MSB first.

Two further addresses are recognised. The first is a broadcast write address that ignores the strap bits; bit 0 of register 2 can switch it off. The second is the alert response address. It answers only while an alert raised on `alert_req_i` is pending, and the answer clears that alert.

Top module: `smb_reg_target`

## Requirements
- R1: After reset, `sda_pd_o` and `alert_o` are 0 and `regs_o` equals `RST_VAL`, where byte k of `regs_o` (bits 8k+7:8k) holds register k.
- R2: Each of SCL and SDA takes on a new level only after the raw input has held that level for `FILT_CYCLES` consecutive clocks. A shorter pulse is ignored and cannot cause a START, a STOP or a sampled bit.
- R3: The target address is binary 10 followed by `addr_lo_i[4:0]`. A write to it (address byte with bit 0 = 0, command byte, data byte) is acknowledged on every byte. `regs_o` does not change until STOP, and at STOP the data byte is written.
- R4: Only bits 1:0 of the command byte select the register; bits 7:2 have no effect.
- R5: A repeated START after the data byte and before STOP discards the pending write, and every register keeps its value.
- R6: A read is a write of the address and command, a repeated START, and then the address with bit 0 = 1. The block acknowledges that address and returns the selected register MSB first.
- R7: A rising edge on `alert_req_i` sets `alert_o`. While it is set, address 0001100 with bit 0 = 1 is acknowledged and answered with {10, `addr_lo_i`, 0}. Once that byte has been sent, `alert_o` clears.
- R8: While `alert_o` is 0, address 0001100 is not acknowledged.
- R9: Address `MASS_ADDR` (default 0111010) with the write bit is accepted for any `addr_lo_i` and writes like R3 when bit 0 of register 2 is 1. When that bit is 0, it is not acknowledged and no register changes.
- R10: An address byte that matches no enabled address is not acknowledged, and SDA stays released until the next START.
- R11: A STOP in the middle of a byte returns the block to idle with SDA released. A START in the middle of a byte restarts address reception, and a complete transfer that follows it works normally.
- R12: `sda_pd_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| addr_lo_i | input | 5 | Strap bits, low five bits of the target address |
| alert_req_i | input | 1 | Alert request; its rising edge sets the pending alert |
| sda_pd_o | output | 1 | SDA pull-down enable (1 drives the line low) |
| alert_o | output | 1 | Pending alert flag |
| regs_o | output | 32 | Register contents, register k in bits 8k+7:8k |

## Verification
The bench uses the default parameters: `FILT_CYCLES` of 5, which is 50 ns at 100 MHz, four registers, reset value 0x00010000 (broadcast enabled) and broadcast address 0111010. Its bus quarter period is 12 clocks. This leaves room for a 3-clock SDA pulse during SCL high that would be a false STOP. It also lets the block's acknowledge and data drive settle well inside each SCL low phase. The bench changes `addr_lo_i` between transfers, so the strap decode, the broadcast path (both enabled and masked) and the alert response byte are all exercised with several target addresses.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_TX,
    ST_WAIT
  } smb_st_e;

  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam logic [1:0] OWN_HI   = 2'b10;
endpackage

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
  parameter int   FILT_CYCLES = 5,
  parameter logic RST_LVL     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= RST_LVL;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign filt_o = filt_q;

  generate
    if (FILT_CYCLES >= 3) begin : g_chk
      // R2: a level change needs the raw input held over at least the last two samples
      a_r2_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_q != $past(filt_q)) |-> ($past(raw_i, 1) == $past(raw_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int N_REG = 4,
  parameter logic [N_REG*8-1:0] RST_VAL = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(N_REG)-1:0] idx_i,
  input  logic [7:0]               wdata_i,
  output logic [N_REG*8-1:0]       regs_o
);
  localparam int IW = $clog2(N_REG);

  generate
    for (genvar i = 0; i < N_REG; i++) begin : g_reg
      logic [7:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     r_q <= RST_VAL[i*8 +: 8];
        else if (we_i && idx_i == IW'(i)) r_q <= wdata_i;
      end
      assign regs_o[i*8 +: 8] = r_q;
    end
  endgenerate
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smb_pkg::*;
#(
  parameter int FILT_CYCLES = 5,
  parameter int N_REG       = 4,
  parameter logic [6:0] MASS_ADDR = 7'b0111010,
  parameter int MW_EN_BIT   = 0,
  parameter logic [N_REG*8-1:0] RST_VAL = 'h0001_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [4:0]         addr_lo_i,
  input  logic               alert_req_i,
  output logic               sda_pd_o,
  output logic               alert_o,
  output logic [N_REG*8-1:0] regs_o
);
  localparam int IW     = $clog2(N_REG);
  localparam int MW_REG = 2;

  logic scl_f, sda_f, scl_q, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;

  smb_glitch_filt #(.FILT_CYCLES(FILT_CYCLES), .RST_LVL(1'b1)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(scl_i), .filt_o(scl_f));
  smb_glitch_filt #(.FILT_CYCLES(FILT_CYCLES), .RST_LVL(1'b1)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(sda_i), .filt_o(sda_f));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;

  smb_st_e        st, nxt_st, byte_nxt;
  logic [3:0]     bit_cnt;
  logic           in_ack, pd_q, byte_ack;
  logic [7:0]     sr, tx_sr;
  logic [IW-1:0]  cmd_idx, wr_idx;
  logic [7:0]     wr_data;
  logic           wr_pend, tx_ara, alert_req_q, alert_q;
  logic           own_hit, mass_hit, ara_hit;
  logic [6:0]     own_addr;
  logic           commit;

  assign own_addr = {OWN_HI, addr_lo_i};
  assign commit   = stop_det & wr_pend;

  smb_regfile #(.N_REG(N_REG), .RST_VAL(RST_VAL)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(commit), .idx_i(wr_idx),
    .wdata_i(wr_data), .regs_o(regs_o));

  // byte decode at the end of the eighth bit
  always_comb begin
    own_hit  = (sr[7:1] == own_addr);
    mass_hit = (sr[7:1] == MASS_ADDR) && !sr[0] && regs_o[MW_REG*8 + MW_EN_BIT];
    ara_hit  = (sr[7:1] == ARA_ADDR) && sr[0] && alert_q;
    byte_ack = 1'b0;
    byte_nxt = ST_WAIT;
    case (st)
      ST_ADDR: begin
        byte_ack = own_hit | mass_hit | ara_hit;
        byte_nxt = ((own_hit && sr[0]) || ara_hit) ? ST_TX : ST_CMD;
      end
      ST_CMD:   begin byte_ack = 1'b1; byte_nxt = ST_WDATA; end
      ST_WDATA: begin byte_ack = 1'b1; byte_nxt = ST_WAIT;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; nxt_st <= ST_IDLE; bit_cnt <= '0; in_ack <= 1'b0;
      pd_q <= 1'b0; sr <= '0; tx_sr <= '0; cmd_idx <= '0; wr_idx <= '0;
      wr_data <= '0; wr_pend <= 1'b0; tx_ara <= 1'b0;
      alert_req_q <= 1'b0; alert_q <= 1'b0;
    end else begin
      alert_req_q <= alert_req_i;
      if (alert_req_i && !alert_req_q) alert_q <= 1'b1;
      if (start_det) begin
        st <= ST_ADDR; bit_cnt <= '0; in_ack <= 1'b0; pd_q <= 1'b0; wr_pend <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; bit_cnt <= '0; in_ack <= 1'b0; pd_q <= 1'b0; wr_pend <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
              sr      <= {sr[6:0], sda_f};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && !in_ack && bit_cnt == 4'd8) begin
              if (byte_ack) begin
                in_ack <= 1'b1;
                pd_q   <= 1'b1;
                nxt_st <= byte_nxt;
              end else begin
                st   <= ST_WAIT;
                pd_q <= 1'b0;
              end
              if (st == ST_CMD) cmd_idx <= sr[IW-1:0];
              if (st == ST_WDATA) begin
                wr_pend <= 1'b1;
                wr_idx  <= cmd_idx;
                wr_data <= sr;
              end
              if (st == ST_ADDR) begin
                tx_ara <= ara_hit;
                tx_sr  <= ara_hit ? {own_addr, 1'b0} : regs_o[{cmd_idx, 3'b000} +: 8];
              end
            end else if (scl_fall && in_ack) begin
              in_ack  <= 1'b0;
              bit_cnt <= '0;
              st      <= nxt_st;
              pd_q    <= (nxt_st == ST_TX) ? ~tx_sr[7] : 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                pd_q <= 1'b0;
                st   <= ST_WAIT;
                if (tx_ara) alert_q <= 1'b0;
              end else begin
                tx_sr <= {tx_sr[6:0], 1'b0};
                pd_q  <= ~tx_sr[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pd_o = pd_q;
  assign alert_o  = alert_q;

  a_r3_commit_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o != $past(regs_o)) |-> $past(stop_det));
  a_r5_start_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !wr_pend);
  a_r11_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st == ST_IDLE) && !sda_pd_o);
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT || st == ST_IDLE) |-> !sda_pd_o);
  a_r12_pd_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pd_o != $past(sda_pd_o)) |-> !scl_f);
  a_r7_alert_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_q) |-> $past(st == ST_TX && tx_ara));
endmodule

// File: tb/smb_reg_target_bench.sv
module smb_reg_target_bench;
  localparam int FILT = 5;
  localparam int Q    = 12;
  localparam logic [6:0]  MASS = 7'b0111010;
  localparam logic [6:0]  ARA  = 7'b0001100;
  localparam logic [31:0] RSTV = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, alert_req = 1'b0;
  logic [4:0] alo = 5'h05;
  logic sda_pd, alert;
  logic [31:0] regs;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pd;

  always #5 clk = ~clk;

  smb_reg_target #(.FILT_CYCLES(FILT)) u_smb_reg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_lo_i(alo), .alert_req_i(alert_req),
    .sda_pd_o(sda_pd), .alert_o(alert), .regs_o(regs));

  int n_chk = 0, n_bad = 0, r12_bad = 0;
  logic [7:0] exp_r [4];
  logic exp_alert = 1'b0;
  logic pd_d = 1'b0;

  function automatic logic [31:0] exp_flat();
    return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
  endfunction

  function automatic logic [6:0] own();
    return {2'b10, alo};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // R12 monitor: pull-down must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && (pd_d !== sda_pd) && scl_m) r12_bad++;
    pd_d = sda_pd;
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask
  task automatic b_start(); sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q); endtask
  task automatic b_stop(); sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q); endtask
  task automatic put_bit(logic b); sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); endtask
  task automatic get_bit(output logic b);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!mack);
  endtask

  task automatic do_write(logic [6:0] a, logic [7:0] cmd, logic [7:0] d, bit abort, string tag);
    logic ack, exp_a;
    exp_a = (a == own()) || (a == MASS && exp_r[2][0]);
    b_start();
    send_byte({a, 1'b0}, ack);
    chk({tag, " addr ack"}, 32'(ack), 32'(exp_a));
    if (ack) begin
      send_byte(cmd, ack);
      chk({tag, " cmd ack"}, 32'(ack), 32'd1);
      send_byte(d, ack);
      chk({tag, " data ack"}, 32'(ack), 32'd1);
      chk({tag, " R3 held before STOP"}, regs, exp_flat());
    end
    if (abort) begin
      b_start(); b_stop();
    end else begin
      b_stop();
      if (exp_a) exp_r[cmd[1:0]] = d;
    end
    chk({tag, " regs"}, regs, exp_flat());
  endtask

  task automatic do_read(logic [7:0] cmd, string tag);
    logic ack;
    logic [7:0] d;
    b_start();
    send_byte({own(), 1'b0}, ack);
    send_byte(cmd, ack);
    b_start();
    send_byte({own(), 1'b1}, ack);
    chk({tag, " read addr ack"}, 32'(ack), 32'd1);
    recv_byte(d, 1'b0);
    b_stop();
    chk({tag, " read data"}, 32'(d), 32'(exp_r[cmd[1:0]]));
  endtask

  task automatic do_ara(string tag);
    logic ack;
    logic [7:0] d;
    b_start();
    send_byte({ARA, 1'b1}, ack);
    chk({tag, " ara ack"}, 32'(ack), 32'(exp_alert));
    if (ack) begin
      recv_byte(d, 1'b0);
      chk({tag, " ara byte"}, 32'(d), 32'({own(), 1'b0}));
      exp_alert = 1'b0;
    end
    b_stop();
    chk({tag, " alert flag"}, 32'(alert), 32'(exp_alert));
  endtask

  initial begin
    logic ack;
    int op;
    logic [1:0] idx;
    void'($urandom(32'd4305));
    for (int k = 0; k < 4; k++) exp_r[k] = RSTV[k*8 +: 8];
    wq(5);
    rst_n = 1;
    wq(2);
    chk("R1 reset regs", regs, RSTV);
    chk("R1 reset pd", 32'(sda_pd), 32'd0);
    chk("R1 reset alert", 32'(alert), 32'd0);

    do_write(own(), 8'hFD, 8'hA5, 1'b0, "R3 R4 write upper bits set");
    do_read(8'h41, "R4 R6 read");
    do_write(own(), 8'h03, 8'h77, 1'b1, "R5 aborted by restart");

    // R11 stop in the middle of an address byte
    b_start();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    b_stop();
    chk("R11 stop mid-byte pd", 32'(sda_pd), 32'd0);
    do_write(own(), 8'h00, 8'h5A, 1'b0, "R11 write after stop");
    // R11 start in the middle of a byte
    b_start();
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    do_write(own(), 8'h02, 8'h81, 1'b0, "R11 restart mid-byte");

    do_write(7'h55, 8'h01, 8'h33, 1'b0, "R10 foreign address");

    alo = 5'h1B;
    do_write(MASS, 8'h00, 8'hC3, 1'b0, "R9 mass enabled");
    do_write(own(), 8'h02, 8'h00, 1'b0, "R9 clear enable");
    do_write(MASS, 8'h01, 8'h11, 1'b0, "R9 mass masked");
    do_write(own(), 8'h02, 8'h01, 1'b0, "R9 restore enable");

    do_ara("R8 no alert");
    alert_req = 1; wq(2); alert_req = 0; wq(2);
    exp_alert = 1'b1;
    chk("R7 alert raised", 32'(alert), 32'd1);
    do_ara("R7 alert response");

    // R2 glitch that would be a STOP must not commit
    b_start();
    send_byte({own(), 1'b0}, ack);
    send_byte(8'h03, ack);
    send_byte(8'h3C, ack);
    sda_m = 0; wq(Q); scl_m = 1; wq(Q);
    sda_m = 1; wq(FILT - 2); sda_m = 0; wq(2*Q);
    chk("R2 short pulse no commit", regs, exp_flat());
    sda_m = 1; wq(Q);
    exp_r[3] = 8'h3C;
    chk("R2 real stop commits", regs, exp_flat());

    for (int i = 0; i < 30; i++) begin
      op  = $urandom_range(0, 3);
      idx = 2'($urandom);
      alo = 5'($urandom);
      wq(1);
      case (op)
        0, 1: do_write(own(), {6'($urandom), idx}, 8'($urandom), 1'b0, "R3 R4 random write");
        2:    do_read({6'($urandom), idx}, "R6 random read");
        default: do_write(own(), {6'($urandom), idx}, 8'($urandom), 1'b1, "R5 random abort");
      endcase
    end

    chk("R12 pull-down moved with SCL high", 32'(r12_bad), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule